// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block generates eight pulse-width-modulated outputs from a single up-counter. Because all channels share that counter, they all run at the same period and their rising edges line up at the start of each period. Each channel has its own compare value, which sets where its pulse ends. A polarity bit can invert each output. A mask bit can park each output at its safe, inactive level.

The counter is clocked from a source that software selects: every system clock, a fixed-rate enable pulse, or an external enable pulse. The selected source is then divided by a power of two. A select code of zero freezes the counter. Software reaches all state through a simple memory-mapped port. A write takes one cycle. A read is combinational and returns 32-bit data. Changes to the period and compare values are held back until the counter wraps, so a period that is already running is never cut short.

Top module: `pwm8_timer`

## Requirements
- R1: Byte offsets are as follows. Control 0x00 holds the prescale code in bits 2:0 and the clock select in bits 4:3. Counter is at 0x04, modulo at 0x08 and counter start at 0x4C. Idle levels are at 0x5C, mask at 0x60 and polarity at 0x70. Channel n has its mode register at 0x0C+8n and its compare register at 0x10+8n. Every register reads back what was last written, except the counter, which reads its live value. After reset, modulo reads 0xFFFF and mask reads 0xFF. Every other register reads 0 after reset.
- R2: Each counter step needs 2^code ticks of the selected source, where code is the value in control bits 2:0. This gives a division from 1 to 128.
- R3: Clock select 0 holds the counter. Select 1 steps it on every clock. Select 2 steps it on cycles where `fix_tick` is high, and select 3 steps it on cycles where `ext_tick` is high.
- R4: On a step, a counter that is equal to or greater than the active modulo reloads the start value. Otherwise it increments. Writing the counter offset loads the start value and restarts the prescaler.
- R5: A channel is in PWM mode when bits 5 and 3 of its mode register are both 1. In PWM mode the channel's level is high while the counter is below the active compare value. A compare of 0 therefore gives 0% duty. A compare above the modulo gives 100% duty.
- R6: While the counter runs, new modulo and compare values become active only at the step that wraps the counter. A write that lands in the wrap cycle itself waits for the following wrap. While the select code is 0, the active copies follow the written values from the next cycle.
- R7: Setting polarity bit n inverts the output of channel n.
- R8: Setting mask bit n forces output n to its inactive level, which equals polarity bit n.
- R9: A channel that is not in PWM mode drives bit n of the idle-level register, after polarity and mask are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate count enable (select 2) |
| ext_tick | input | 1 | External count enable (select 3) |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 8 | Channel outputs |

## Verification
The risky overlap is a register write that lands in the same cycle as the counter wrap. In that cycle the wrap loads the active modulo and compare copies while the bus updates the written copies. The bench provokes this case directly. It polls the counter through the bus until it reads the modulo value, then issues a modulo write on that exact cycle. It judges the result by reading the counter back: the next period must still reach the old limit, and only the period after it may use the new one. Random writes that fall across wraps are also compared, cycle by cycle, against a bench model of the outputs.

// File: rtl/pwm8_timer.sv
module pwm8_timer #(
  parameter int CH = 8,
  parameter int CW = 16,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fix_tick,
  input  logic          ext_tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [CH-1:0] pwm_out
);
  localparam logic [AW-1:0] A_CTL   = AW'(8'h00);
  localparam logic [AW-1:0] A_CNT   = AW'(8'h04);
  localparam logic [AW-1:0] A_MOD   = AW'(8'h08);
  localparam logic [AW-1:0] A_START = AW'(8'h4C);
  localparam logic [AW-1:0] A_IDLE  = AW'(8'h5C);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h60);
  localparam logic [AW-1:0] A_POL   = AW'(8'h70);
  localparam int CH_BASE = 12;
  localparam int CH_STRIDE = 8;

  logic [4:0]    ctl;
  logic [CW-1:0] cnt, mod_wr, mod_act, start_val;
  logic [CH-1:0] idle_lvl, out_mask, pol;
  logic [7:0]    presc;
  logic [5:0]    mode   [CH];
  logic [CW-1:0] cmp_wr [CH];
  logic [CW-1:0] cmp_act[CH];

  logic       running, src, step, cnt_wr, wrap;
  logic [7:0] div_lim;

  assign running = ctl[4:3] != 2'd0;
  assign div_lim = (8'd1 << ctl[2:0]) - 8'd1;
  assign cnt_wr  = bus_we && bus_addr == A_CNT;
  assign step    = src && presc >= div_lim;
  assign wrap    = step && cnt >= mod_act && !cnt_wr;

  always_comb begin
    case (ctl[4:3])
      2'd1:    src = 1'b1;
      2'd2:    src = fix_tick;
      2'd3:    src = ext_tick;
      default: src = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      presc <= '0;
    end else if (cnt_wr) begin
      cnt   <= start_val;
      presc <= '0;
    end else if (src) begin
      presc <= step ? 8'd0 : presc + 8'd1;
      if (step) cnt <= (cnt >= mod_act) ? start_val : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= '0;
      mod_wr    <= '1;
      mod_act   <= '1;
      start_val <= '0;
      idle_lvl  <= '0;
      out_mask  <= '1;
      pol       <= '0;
    end else begin
      if (!running || wrap) mod_act <= mod_wr;
      if (bus_we) begin
        case (bus_addr)
          A_CTL:   ctl       <= bus_wdata[4:0];
          A_MOD:   mod_wr    <= bus_wdata[CW-1:0];
          A_START: start_val <= bus_wdata[CW-1:0];
          A_IDLE:  idle_lvl  <= bus_wdata[CH-1:0];
          A_MASK:  out_mask  <= bus_wdata[CH-1:0];
          A_POL:   pol       <= bus_wdata[CH-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    localparam logic [AW-1:0] A_MODE = AW'(CH_BASE + CH_STRIDE * i);
    localparam logic [AW-1:0] A_CMP  = AW'(CH_BASE + CH_STRIDE * i + 4);
    logic lvl;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode[i]    <= '0;
        cmp_wr[i]  <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (!running || wrap) cmp_act[i] <= cmp_wr[i];
        if (bus_we && bus_addr == A_MODE) mode[i]   <= bus_wdata[5:0];
        if (bus_we && bus_addr == A_CMP)  cmp_wr[i] <= bus_wdata[CW-1:0];
      end
    end

    assign lvl = (mode[i][5] && mode[i][3]) ? (cnt < cmp_act[i]) : idle_lvl[i];
    assign pwm_out[i] = out_mask[i] ? pol[i] : (lvl ^ pol[i]);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL:   bus_rdata = DW'(ctl);
      A_CNT:   bus_rdata = DW'(cnt);
      A_MOD:   bus_rdata = DW'(mod_wr);
      A_START: bus_rdata = DW'(start_val);
      A_IDLE:  bus_rdata = DW'(idle_lvl);
      A_MASK:  bus_rdata = DW'(out_mask);
      A_POL:   bus_rdata = DW'(pol);
      default: ;
    endcase
    for (int i = 0; i < CH; i++) begin
      if (bus_addr == AW'(CH_BASE + CH_STRIDE * i))     bus_rdata = DW'(mode[i]);
      if (bus_addr == AW'(CH_BASE + CH_STRIDE * i + 4)) bus_rdata = DW'(cmp_wr[i]);
    end
  end

  assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cnt_wr) |=> $stable(cnt));

  assert_wrap_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == $past(start_val));

  assert_presc_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> presc == 8'd0);

  assert_mod_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wrap) |=> $stable(mod_act));

  assert_mask_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mask == '1) |-> (pwm_out == pol));
endmodule

// File: tb/pwm8_timer_bench.sv
module pwm8_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fix_tick = 1'b0, ext_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pwm_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  pwm8_timer u_pwm8_timer (
    .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic [4:0]  m_ctl;
  logic [15:0] m_cnt, m_mod, m_moda, m_start;
  logic [7:0]  m_idle, m_mask, m_pol, m_presc;
  logic [5:0]  m_mode[8];
  logic [15:0] m_cmp[8], m_cmpa[8];

  always @(posedge clk or negedge rst_n) begin : model
    bit s, st, cw, wr;
    int lim;
    if (!rst_n) begin
      m_ctl <= 0; m_cnt <= 0; m_mod <= 16'hFFFF; m_moda <= 16'hFFFF; m_start <= 0;
      m_idle <= 0; m_mask <= 8'hFF; m_pol <= 0; m_presc <= 0;
      for (int i = 0; i < 8; i++) begin m_mode[i] <= 0; m_cmp[i] <= 0; m_cmpa[i] <= 0; end
    end else begin
      case (m_ctl[4:3])
        2'd1: s = 1; 2'd2: s = fix_tick; 2'd3: s = ext_tick; default: s = 0;
      endcase
      lim = (1 << m_ctl[2:0]) - 1;
      st = s && (int'(m_presc) >= lim);
      cw = bus_we && bus_addr == 8'h04;
      wr = st && m_cnt >= m_moda && !cw;
      if (cw) begin m_cnt <= m_start; m_presc <= 0; end
      else if (s) begin
        m_presc <= st ? 8'd0 : m_presc + 8'd1;
        if (st) m_cnt <= (m_cnt >= m_moda) ? m_start : m_cnt + 16'd1;
      end
      if (m_ctl[4:3] == 0 || wr) begin
        m_moda <= m_mod;
        for (int i = 0; i < 8; i++) m_cmpa[i] <= m_cmp[i];
      end
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_ctl <= bus_wdata[4:0];
          8'h08: m_mod <= bus_wdata[15:0];
          8'h4C: m_start <= bus_wdata[15:0];
          8'h5C: m_idle <= bus_wdata[7:0];
          8'h60: m_mask <= bus_wdata[7:0];
          8'h70: m_pol <= bus_wdata[7:0];
          default: ;
        endcase
        for (int i = 0; i < 8; i++) begin
          if (bus_addr == 8'(12 + 8*i)) m_mode[i] <= bus_wdata[5:0];
          if (bus_addr == 8'(16 + 8*i)) m_cmp[i] <= bus_wdata[15:0];
        end
      end
    end
  end

  function automatic logic [7:0] exp_out();
    logic [7:0] o;
    for (int i = 0; i < 8; i++) begin
      logic l;
      l = (m_mode[i][5] && m_mode[i][3]) ? (m_cnt < m_cmpa[i]) : m_idle[i];
      o[i] = m_mask[i] ? m_pol[i] : (l ^ m_pol[i]);
    end
    return o;
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] v;
    case (a)
      8'h00: v = 32'(m_ctl);  8'h04: v = 32'(m_cnt);  8'h08: v = 32'(m_mod);
      8'h4C: v = 32'(m_start); 8'h5C: v = 32'(m_idle); 8'h60: v = 32'(m_mask);
      8'h70: v = 32'(m_pol);  default: v = 0;
    endcase
    for (int i = 0; i < 8; i++) begin
      if (a == 8'(12 + 8*i)) v = 32'(m_mode[i]);
      if (a == 8'(16 + 8*i)) v = 32'(m_cmp[i]);
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  bit rnd_src = 1'b1;

  task automatic tick();
    if (rnd_src) begin fix_tick = 1'($urandom); ext_tick = 1'($urandom); end
    @(posedge clk);
    @(negedge clk);
    chk(pwm_out === exp_out(), "R5/R7/R8/R9", "pwm_out vs model", pwm_out, exp_out());
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic count_high(int ch, int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin tick(); hi += pwm_out[ch]; end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    int hi;
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(8'h60, v); chk(v == 32'hFF, "R1", "mask reset", v, 32'hFF);
    rd(8'h08, v); chk(v == 32'hFFFF, "R1", "modulo reset", v, 32'hFFFF);
    rd(8'h4C, v); chk(v == 0, "R1", "start reset", v, 0);
    rd(8'h5C, v); chk(v == 0, "R1", "idle reset", v, 0);
    rd(8'h00, v); chk(v == 0, "R1", "control reset", v, 0);
    chk(pwm_out == 8'h00, "R8", "outputs masked low at reset", pwm_out, 0);

    // R1 readback
    wr(8'h24, 32'h28); rd(8'h24, v); chk(v == 32'h28, "R1", "ch3 mode readback", v, 32'h28);
    wr(8'h38, 32'h1234); rd(8'h38, v); chk(v == 32'h1234, "R1", "ch5 compare readback", v, 32'h1234);

    // R3 stopped counter holds
    rd(8'h04, v); ticks(5);
    begin logic [31:0] v2; rd(8'h04, v2); chk(v2 == v, "R3", "stopped counter holds", v2, v); end

    // R2 prescaler divide by 4
    wr(8'h04, 0); wr(8'h00, {27'd0, 2'd1, 3'd2}); ticks(8);
    rd(8'h04, v); chk(v == 2, "R2", "divide-by-4 after 8 clocks", v, 2);

    // R4 wrap to start value
    wr(8'h00, 0); wr(8'h08, 4); wr(8'h4C, 2); wr(8'h04, 0);
    wr(8'h00, {27'd0, 2'd1, 3'd0}); ticks(3);
    rd(8'h04, v); chk(v == 2, "R4", "wrap after modulo reloads start", v, 2);

    // R5 duty setup: period 10 on channel 0
    wr(8'h00, 0); wr(8'h08, 9); wr(8'h4C, 0); wr(8'h0C, 32'h28); wr(8'h10, 0);
    wr(8'h60, 8'hFE); wr(8'h04, 0); wr(8'h00, 32'h08);
    count_high(0, 20, hi); chk(hi == 0, "R5", "compare 0 gives 0% duty", hi, 0);
    wr(8'h00, 0); wr(8'h10, 12); wr(8'h00, 32'h08);
    count_high(0, 20, hi); chk(hi == 20, "R5", "compare above modulo gives 100%", hi, 20);
    wr(8'h00, 0); wr(8'h10, 3); wr(8'h00, 32'h08);
    count_high(0, 20, hi); chk(hi == 6, "R5", "compare 3 of 10 duty", hi, 6);

    // R7 polarity
    wr(8'h70, 8'h01);
    count_high(0, 20, hi); chk(hi == 14, "R7", "inverted duty", hi, 14);

    // R8 mask forces the inactive level
    wr(8'h60, 8'hFF);
    count_high(0, 20, hi); chk(hi == 20, "R8", "masked output sits at polarity", hi, 20);
    chk(pwm_out == 8'h01, "R8", "all masked equals polarity", pwm_out, 8'h01);

    // R9 idle level for a channel outside PWM mode
    wr(8'h14, 0); wr(8'h5C, 8'h02); wr(8'h60, 8'hFC);
    ticks(2); chk(pwm_out[1] == 1'b1, "R9", "channel 1 idle level", pwm_out[1], 1);

    // R6 modulo write landing in the wrap cycle
    for (int i = 0; i < 30; i++) begin rd(8'h04, v); if (v == 9) break; tick(); end
    chk(v == 9, "R6", "counter reached modulo", v, 9);
    wr(8'h08, 4);
    rd(8'h04, v); chk(v == 0, "R6", "wrap happened", v, 0);
    ticks(9); rd(8'h04, v); chk(v == 9, "R6", "old period kept", v, 9);
    ticks(1); ticks(4); rd(8'h04, v); chk(v == 4, "R6", "new limit reached", v, 4);
    ticks(1); rd(8'h04, v); chk(v == 0, "R6", "new period wraps at 4", v, 0);

    // constrained random mix
    for (int it = 0; it < 6000; it++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 70) tick();
      else if (op < 90) begin
        int sel;
        sel = int'($urandom % 9);
        case (sel)
          0: wr(8'h00, {27'd0, 2'($urandom), 3'($urandom % 3)});
          1: wr(8'h08, $urandom % 40);
          2: wr(8'h4C, $urandom % 12);
          3: wr(8'h5C, $urandom);
          4: wr(8'h60, $urandom);
          5: wr(8'h70, $urandom);
          6: wr(8'(12 + 8 * ($urandom % 8)), ($urandom % 2) ? 32'h28 : 32'($urandom % 64));
          7: wr(8'(16 + 8 * ($urandom % 8)), $urandom % 45);
          default: wr(8'h04, $urandom);
        endcase
      end else begin
        logic [7:0] a;
        a = ($urandom % 2) ? 8'h04 : 8'($urandom % 8'h74);
        rd(a, v);
        chk(v == exp_rd(a), a == 8'h04 ? "R4" : "R1", "random readback", v, exp_rd(a));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule